// File: doc/BRIEF.md
# Single-Move Instruction Sequencer

This block sequences a CPU whose only instruction is a move: every instruction copies one byte from a source location to a destination location. Each instruction takes four cycles. First the source address byte comes out of program memory into a single shared address register. Next the byte at that address is captured in a holding register. Then the destination address byte is fetched into the same shared register. Finally the held byte is written to the destination. The program counter steps once after each of the two fetches.

Addresses in the window 0x20 through 0x2F do not go to the register port. They go to data memory, and an external data pointer supplies the data memory address. Only the upper four address bits are decoded for this. While a data memory transfer is in progress, the program counter stops driving its address bus. The decoder drives a pair of complementary selects that name the active address source.

Top module: `msq_move_seq`

## Requirements
- R1: A synchronous active-high reset sets the program counter to 0x0000 and selects the source-fetch phase. The phase strobe reads 4'b0001.
- R2: Exactly one bit of the four-bit phase strobe is high in each cycle. The phases cycle in the order source fetch (bit 0), source read (bit 1), destination fetch (bit 2), destination write (bit 3), then back to bit 0.
- R3: The program counter drives the program address during both fetch phases. It increases by one after each fetch phase, so it advances by two per instruction.
- R4: The byte read from program memory in a fetch phase is loaded into the shared address register. The register port address shows this value in the phase that follows.
- R5: When the shared address has upper nibble 4'b0010, the transfer phase uses data memory at the pointer input value. sel_ptr is 1 and sel_areg is 0. The lower nibble has no effect on this choice.
- R6: Any other shared address uses the register port at that address, with sel_areg 1 and sel_ptr 0.
- R7: sel_areg and sel_ptr are complementary in every cycle.
- R8: prog_oe is low in every cycle that has a data memory read or write, and high in all other cycles.
- R9: The byte read in the source-read phase is presented unchanged as write data in the destination-write phase. After the instruction, the destination holds that byte.
- R10: Reads of either port occur only in the source-read phase. Writes occur only in the destination-write phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_addr | output | 16 | Program address (zero while not driven) |
| prog_oe | output | 1 | Program counter drives prog_addr |
| prog_rdata | input | 8 | Program memory read byte |
| ptr_val | input | 16 | Data pointer register value |
| dmem_addr | output | 16 | Data memory address |
| dmem_rd | output | 1 | Data memory read strobe |
| dmem_wr | output | 1 | Data memory write strobe |
| dmem_wdata | output | 8 | Data memory write byte |
| dmem_rdata | input | 8 | Data memory read byte |
| reg_addr | output | 8 | Register port address |
| reg_rd | output | 1 | Register read strobe |
| reg_wr | output | 1 | Register write strobe |
| reg_wdata | output | 8 | Register write byte |
| reg_rdata | input | 8 | Register read byte |
| sel_areg | output | 1 | Shared address register selected |
| sel_ptr | output | 1 | Data pointer selected |
| phase_strb | output | 4 | One-hot phase strobe |
| areg_load | output | 1 | Shared address register load strobe |
| tmp_load | output | 1 | Holding register load strobe |

## Verification
A phase counter that slips shows up within one cycle: the strobe stops being one-hot or stops rotating, and the fetch address or a port strobe appears in the wrong cycle. A wrong shared address or decode shows up in the same transfer phase, because the wrong port strobe rises or the wrong address is driven. A corrupted holding register is visible at the write data in the fourth phase, and afterwards in the contents of the destination. The counter value is checked at every fetch, so a missed or doubled increment is seen within two cycles.

// File: rtl/msq_pkg.sv
package msq_pkg;
   localparam int unsigned NUM_PHASES = 4;

   typedef enum logic [1:0] {
      PH_SRC_FETCH = 2'd0,
      PH_SRC_READ  = 2'd1,
      PH_DST_FETCH = 2'd2,
      PH_DST_WRITE = 2'd3
   } phase_e;
endpackage

// File: rtl/msq_phase_ctr.sv
module msq_phase_ctr
   import msq_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst,
   output phase_e                phase,
   output logic [NUM_PHASES-1:0] strobe
);
   phase_e phase_q;

   always_ff @(posedge clk) begin
      if (rst) phase_q <= PH_SRC_FETCH;
      else     phase_q <= phase_e'(phase_q + 2'd1);
   end

   assign phase = phase_q;

   for (genvar i = 0; i < NUM_PHASES; i++) begin : g_strb
      assign strobe[i] = (phase_q == phase_e'(i));
   end
endmodule

// File: rtl/msq_pc.sv
module msq_pc #(
   parameter int unsigned PC_W = 16
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            inc,
   input  logic            oe,
   output logic [PC_W-1:0] bus
);
   logic [PC_W-1:0] pc_q;

   always_ff @(posedge clk) begin
      if (rst)      pc_q <= '0;
      else if (inc) pc_q <= pc_q + 1'b1;
   end

   assign bus = oe ? pc_q : '0;
endmodule

// File: rtl/msq_addr_decode.sv
module msq_addr_decode #(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned TAG_W       = 4,
   parameter logic [TAG_W-1:0] REDIRECT_TAG = 4'h2,
   parameter bit          NIBBLE_ONLY = 1'b1,
   parameter logic [ADDR_W-TAG_W-1:0] EXACT_LOW = '0
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              sel_areg,
   output logic              sel_ptr
);
   localparam int unsigned LOW_W = ADDR_W - TAG_W;

   logic hit;

   if (NIBBLE_ONLY) begin : g_window
      assign hit = (addr[ADDR_W-1 -: TAG_W] == REDIRECT_TAG);
   end else begin : g_single
      assign hit = (addr[ADDR_W-1 -: TAG_W] == REDIRECT_TAG) &&
                   (addr[LOW_W-1:0] == EXACT_LOW);
   end

   assign sel_ptr  = hit;
   assign sel_areg = ~hit;
endmodule

// File: rtl/msq_move_seq.sv
module msq_move_seq
   import msq_pkg::*;
#(
   parameter int unsigned DATA_W       = 8,
   parameter int unsigned PC_W         = 16,
   parameter int unsigned PTR_W        = 16,
   parameter int unsigned TAG_W        = 4,
   parameter logic [3:0]  REDIRECT_TAG = 4'h2,
   parameter bit          NIBBLE_ONLY  = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   output logic [PC_W-1:0]   prog_addr,
   output logic              prog_oe,
   input  logic [DATA_W-1:0] prog_rdata,
   input  logic [PTR_W-1:0]  ptr_val,
   output logic [PTR_W-1:0]  dmem_addr,
   output logic              dmem_rd,
   output logic              dmem_wr,
   output logic [DATA_W-1:0] dmem_wdata,
   input  logic [DATA_W-1:0] dmem_rdata,
   output logic [DATA_W-1:0] reg_addr,
   output logic              reg_rd,
   output logic              reg_wr,
   output logic [DATA_W-1:0] reg_wdata,
   input  logic [DATA_W-1:0] reg_rdata,
   output logic              sel_areg,
   output logic              sel_ptr,
   output logic [3:0]        phase_strb,
   output logic              areg_load,
   output logic              tmp_load
);
   localparam int unsigned ADDR_W = DATA_W;

   if (TAG_W >= ADDR_W) begin : g_bad_tag
      $error("msq_move_seq: TAG_W must be narrower than the address");
   end
   if (PC_W < ADDR_W) begin : g_bad_pc
      $error("msq_move_seq: PC_W must be at least the address width");
   end
   if (NUM_PHASES != 4) begin : g_bad_phases
      $error("msq_move_seq: sequencer assumes four phases");
   end

   phase_e             phase;
   logic [3:0]         strb;
   logic [ADDR_W-1:0]  areg_q;
   logic [DATA_W-1:0]  tmp_q;
   logic               fetch, xfer, dmem_go;

   msq_phase_ctr u_phase (
      .clk    (clk),
      .rst    (rst),
      .phase  (phase),
      .strobe (strb)
   );

   assign fetch = strb[PH_SRC_FETCH] | strb[PH_DST_FETCH];
   assign xfer  = strb[PH_SRC_READ]  | strb[PH_DST_WRITE];

   msq_addr_decode #(
      .ADDR_W       (ADDR_W),
      .TAG_W        (TAG_W),
      .REDIRECT_TAG (REDIRECT_TAG[TAG_W-1:0]),
      .NIBBLE_ONLY  (NIBBLE_ONLY),
      .EXACT_LOW    ('0)
   ) u_dec (
      .addr     (areg_q),
      .sel_areg (sel_areg),
      .sel_ptr  (sel_ptr)
   );

   assign dmem_go = xfer & sel_ptr;
   assign prog_oe = ~dmem_go;

   msq_pc #(.PC_W(PC_W)) u_pc (
      .clk (clk),
      .rst (rst),
      .inc (fetch),
      .oe  (prog_oe),
      .bus (prog_addr)
   );

   always_ff @(posedge clk) begin
      if (rst)        areg_q <= '0;
      else if (fetch) areg_q <= prog_rdata;
   end

   always_ff @(posedge clk) begin
      if (rst)                        tmp_q <= '0;
      else if (strb[PH_SRC_READ])     tmp_q <= sel_ptr ? dmem_rdata : reg_rdata;
   end

   assign dmem_rd    = strb[PH_SRC_READ]  & sel_ptr;
   assign dmem_wr    = strb[PH_DST_WRITE] & sel_ptr;
   assign reg_rd     = strb[PH_SRC_READ]  & sel_areg;
   assign reg_wr     = strb[PH_DST_WRITE] & sel_areg;
   assign dmem_addr  = dmem_go ? ptr_val : '0;
   assign reg_addr   = areg_q;
   assign dmem_wdata = tmp_q;
   assign reg_wdata  = tmp_q;
   assign phase_strb = strb;
   assign areg_load  = fetch;
   assign tmp_load   = strb[PH_SRC_READ];
endmodule

// File: rtl/msq_move_seq_chk.sv
module msq_move_seq_chk #(
   parameter int unsigned PC_W = 16
) (
   input logic            clk,
   input logic            rst,
   input logic [3:0]      phase_strb,
   input logic [PC_W-1:0] prog_addr,
   input logic            prog_oe,
   input logic            dmem_rd,
   input logic            dmem_wr,
   input logic            reg_rd,
   input logic            reg_wr,
   input logic            sel_areg,
   input logic            sel_ptr
);
   // R2
   phase_onehot_chk: assert property (@(posedge clk) disable iff (rst)
      $countones(phase_strb) == 1);

   // R2
   phase_order_chk: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> phase_strb == {$past(phase_strb[2:0]), $past(phase_strb[3])});

   // R3
   pc_step_chk: assert property (@(posedge clk) disable iff (rst)
      (phase_strb[0] || phase_strb[2]) |-> ##2 (prog_addr == $past(prog_addr, 2) + 1'b1));

   // R7
   sel_compl_chk: assert property (@(posedge clk) disable iff (rst)
      sel_areg != sel_ptr);

   // R8
   pc_float_chk: assert property (@(posedge clk) disable iff (rst)
      (dmem_rd || dmem_wr) |-> !prog_oe);

   // R10
   write_phase_chk: assert property (@(posedge clk) disable iff (rst)
      (dmem_wr || reg_wr) |-> phase_strb[3]);

   // R10
   read_phase_chk: assert property (@(posedge clk) disable iff (rst)
      (dmem_rd || reg_rd) |-> phase_strb[1]);
endmodule

bind msq_move_seq msq_move_seq_chk #(.PC_W(PC_W)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .phase_strb (phase_strb),
   .prog_addr  (prog_addr),
   .prog_oe    (prog_oe),
   .dmem_rd    (dmem_rd),
   .dmem_wr    (dmem_wr),
   .reg_rd     (reg_rd),
   .reg_wr     (reg_wr),
   .sel_areg   (sel_areg),
   .sel_ptr    (sel_ptr)
);

// File: tb/msq_move_seq_test.sv
module msq_move_seq_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] prog_addr;
   logic        prog_oe;
   logic [7:0]  prog_rdata;
   logic [15:0] ptr_val = 16'h0;
   logic [15:0] dmem_addr;
   logic        dmem_rd, dmem_wr;
   logic [7:0]  dmem_wdata, dmem_rdata;
   logic [7:0]  reg_addr;
   logic        reg_rd, reg_wr;
   logic [7:0]  reg_wdata, reg_rdata;
   logic        sel_areg, sel_ptr;
   logic [3:0]  phase_strb;
   logic        areg_load, tmp_load;

   logic [7:0] prog [256];
   logic [7:0] dmem [256];
   logic [7:0] regs [256];

   int checks = 0;
   int errs   = 0;
   bit done   = 0;

   always #2 clk = ~clk;

   msq_move_seq uut (
      .clk(clk), .rst(rst), .prog_addr(prog_addr), .prog_oe(prog_oe),
      .prog_rdata(prog_rdata), .ptr_val(ptr_val), .dmem_addr(dmem_addr),
      .dmem_rd(dmem_rd), .dmem_wr(dmem_wr), .dmem_wdata(dmem_wdata),
      .dmem_rdata(dmem_rdata), .reg_addr(reg_addr), .reg_rd(reg_rd),
      .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .sel_areg(sel_areg), .sel_ptr(sel_ptr), .phase_strb(phase_strb),
      .areg_load(areg_load), .tmp_load(tmp_load)
   );

   assign prog_rdata = prog[prog_addr[7:0]];
   assign dmem_rdata = dmem[dmem_addr[7:0]];
   assign reg_rdata  = regs[reg_addr];

   always @(posedge clk) begin
      if (dmem_wr) dmem[dmem_addr[7:0]] <= dmem_wdata;
      if (reg_wr)  regs[reg_addr]       <= reg_wdata;
   end

   // {src, dst, pointer}
   localparam logic [31:0] VEC [8] = '{
      {8'h10, 8'h11, 16'h0040},   // register to register
      {8'h20, 8'h12, 16'h0005},   // window base as source
      {8'h13, 8'h2F, 16'h0007},   // window top as destination
      {8'h2A, 8'h25, 16'h0009},   // memory to memory
      {8'h1F, 8'h30, 16'h0011},   // just below and just above window
      {8'h30, 8'h1F, 16'h0012},
      {8'hFF, 8'h00, 16'h0013},
      {8'h27, 8'h80, 16'h0033}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   initial begin
      int unsigned cyc = 0;
      while (!done) begin
         @(posedge clk);
         cyc++;
         if (cyc > 5000) begin
            errs++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("  Result: errors=%0d of %0d checks", errs, checks);
            $finish;
         end
      end
   end

   initial begin
      logic [15:0] pc;
      for (int i = 0; i < 256; i++) begin
         regs[i] = 8'(i) ^ 8'hA5;
         dmem[i] = 8'(i * 3 + 1);
         prog[i] = 8'h00;
      end
      for (int i = 0; i < 8; i++) begin
         prog[2*i]   = VEC[i][31:24];
         prog[2*i+1] = VEC[i][23:16];
      end

      @(posedge clk); @(posedge clk);
      @(negedge clk);
      // R1: reset state
      chk("R1 pc", {16'h0, prog_addr}, 32'h0);
      chk("R1 phase", {28'h0, phase_strb}, 32'h1);
      rst = 1'b0;

      pc = 16'h0;
      for (int v = 0; v < 8; v++) begin
         logic [7:0] src, dst, expd;
         logic [15:0] ptr;
         bit sred, dred;
         src  = VEC[v][31:24];
         dst  = VEC[v][23:16];
         ptr  = VEC[v][15:0];
         sred = (src[7:4] == 4'h2);
         dred = (dst[7:4] == 4'h2);
         expd = sred ? dmem[ptr[7:0]] : regs[src];
         ptr_val = ptr;

         // phase 0: source fetch
         chk("R2 ph0", {28'h0, phase_strb}, 32'h1);
         chk("R3 fetch src addr", {16'h0, prog_addr}, {16'h0, pc});
         chk("R3 oe", {31'h0, prog_oe}, 32'h1);
         @(negedge clk);
         // phase 1: source read
         chk("R2 ph1", {28'h0, phase_strb}, 32'h2);
         chk("R4 areg src", {24'h0, reg_addr}, {24'h0, src});
         chk("R7 sel", {30'h0, sel_ptr, sel_areg}, sred ? 32'h2 : 32'h1);
         if (sred) begin
            chk("R5 dmem_rd", {30'h0, dmem_rd, reg_rd}, 32'h2);
            chk("R5 dmem addr", {16'h0, dmem_addr}, {16'h0, ptr});
            chk("R8 pc float", {31'h0, prog_oe}, 32'h0);
         end else begin
            chk("R6 reg_rd", {30'h0, dmem_rd, reg_rd}, 32'h1);
            chk("R8 pc kept", {31'h0, prog_oe}, 32'h1);
         end
         @(negedge clk);
         // phase 2: destination fetch
         chk("R2 ph2", {28'h0, phase_strb}, 32'h4);
         chk("R3 fetch dst addr", {16'h0, prog_addr}, {16'h0, pc + 16'h1});
         chk("R10 no access", {28'h0, dmem_rd, dmem_wr, reg_rd, reg_wr}, 32'h0);
         @(negedge clk);
         // phase 3: destination write
         chk("R2 ph3", {28'h0, phase_strb}, 32'h8);
         chk("R4 areg dst", {24'h0, reg_addr}, {24'h0, dst});
         if (dred) begin
            chk("R5 dmem_wr", {30'h0, dmem_wr, reg_wr}, 32'h2);
            chk("R5 dmem waddr", {16'h0, dmem_addr}, {16'h0, ptr});
            chk("R9 wdata", {24'h0, dmem_wdata}, {24'h0, expd});
            chk("R8 pc float wr", {31'h0, prog_oe}, 32'h0);
         end else begin
            chk("R6 reg_wr", {30'h0, dmem_wr, reg_wr}, 32'h1);
            chk("R9 wdata", {24'h0, reg_wdata}, {24'h0, expd});
         end
         @(negedge clk);
         chk("R9 dest", {24'h0, dred ? dmem[ptr[7:0]] : regs[dst]}, {24'h0, expd});
         pc = pc + 16'h2;
      end

      // R3: next fetch after eight instructions
      chk("R3 pc after run", {16'h0, prog_addr}, 32'h10);

      // R1: reset taken in the middle of an instruction
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      chk("R1 mid reset pc", {16'h0, prog_addr}, 32'h0);
      chk("R1 mid reset phase", {28'h0, phase_strb}, 32'h1);
      rst = 1'b0;
      @(negedge clk);
      chk("R2 after reset", {28'h0, phase_strb}, 32'h2);

      done = 1;
      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule